// File: doc/BRIEF.md
# Register ALU with Barrel Shifter

A purely combinational arithmetic, logic and shift unit for the execute stage of a small load/store processor. It takes two register operands, a constant shift count taken from the instruction, and a 6-bit operation select whose values match the R-type function codes. It produces one result word and a flag that is high when that word is zero. Because the flag follows a subtract, equality branches can reuse the subtract path.

Immediate operands reach the second input already zero-extended, so the unit never sign- or zero-extends anything itself. Every shift moves the first operand. A constant shift takes its count from the dedicated shift-count input. A variable shift takes its count from the low bits of the second operand. Add and subtract wrap silently and have no overflow output.

Top module: `reg_alu`

## Requirements
- R1: Select 32 (add) gives `a_i + b_i` modulo 2^DATA_W, with no overflow indication.
- R2: Select 34 (subtract) gives `a_i - b_i` modulo 2^DATA_W.
- R3: Selects 36, 37 and 38 give the bitwise AND, OR and XOR of the operands.
- R4: Select 39 gives the bitwise complement of `a_i | b_i`.
- R5: Selects 0 (left) and 2 (logical right) shift `a_i` by `shamt_i`, filling with zeros; `b_i` has no effect on them.
- R6: Selects 4 (left) and 6 (logical right) shift `a_i` by the low log2(DATA_W) bits of `b_i`; upper bits of `b_i` have no effect.
- R7: Selects 3 (count from `shamt_i`) and 7 (count from the low bits of `b_i`) shift `a_i` right and fill vacated bits with `a_i`'s sign bit.
- R8: Select 42 gives 1 when `a_i` is less than `b_i` as signed two's-complement values, and 0 otherwise.
- R9: `zero_o` is 1 exactly when `result_o` is all zeros.
- R10: Any select value not listed above gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | DATA_W | First operand; the value that shifts move |
| b_i | input | DATA_W | Second operand, or zero-extended immediate; its low bits give the variable shift count |
| shamt_i | input | SHAMT_W | Constant shift count |
| op_i | input | 6 | Operation select (function code) |
| result_o | output | DATA_W | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The bench builds the unit with DATA_W = 32 and SHAMT_W = 5. With these values every shift count from 0 to 31 can be reached, and so can the sign boundary between 0x7FFFFFFF and 0x80000000, where the signed compare and the sign-filling shift differ from their unsigned forms. Directed vectors cover the wrap points, the extreme shift counts and count operands with upper bits set. Pseudo-random operands are also applied to every select, including unassigned codes.

// File: rtl/reg_alu_pkg.sv
package reg_alu_pkg;

  typedef enum logic [5:0] {
    OP_SLL  = 6'd0,
    OP_SRL  = 6'd2,
    OP_SRA  = 6'd3,
    OP_SLLV = 6'd4,
    OP_SRLV = 6'd6,
    OP_SRAV = 6'd7,
    OP_ADD  = 6'd32,
    OP_SUB  = 6'd34,
    OP_AND  = 6'd36,
    OP_OR   = 6'd37,
    OP_XOR  = 6'd38,
    OP_NOR  = 6'd39,
    OP_SLT  = 6'd42
  } alu_op_e;

  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_OR  = 2'd1,
    LF_XOR = 2'd2,
    LF_NOR = 2'd3
  } logic_fn_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              lt_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              ovf;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};
  // signed less-than: sign of difference corrected by overflow
  assign ovf   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  assign lt_o  = sum_o[MSB] ^ ovf;

  always_comb begin
    if (sub_i) begin
      // R2
      sub_wrap_chk: assert (sum_o + b_i == a_i);
      // R8
      slt_sign_chk: assert (lt_o == ($signed(a_i) < $signed(b_i)));
    end else begin
      // R1
      add_wrap_chk: assert (sum_o - b_i == a_i);
    end
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import reg_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic_fn_e         fn_i,
  output logic [DATA_W-1:0] q_o
);

  always_comb begin
    unique case (fn_i)
      LF_AND:  q_o = a_i & b_i;
      LF_OR:   q_o = a_i | b_i;
      LF_XOR:  q_o = a_i ^ b_i;
      default: q_o = ~(a_i | b_i);
    endcase
  end

  always_comb begin
    if (fn_i == LF_NOR) begin
      // R4
      nor_cover_chk: assert ((q_o | a_i | b_i) == {DATA_W{1'b1}});
      // R4
      nor_disjoint_chk: assert ((q_o & (a_i | b_i)) == '0);
    end
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  d_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               left_i,
  input  logic               arith_i,
  output logic [DATA_W-1:0]  q_o
);
  localparam int MSB = DATA_W - 1;

  logic              fill;
  logic [DATA_W-1:0] l_st [SHAMT_W+1];
  logic [DATA_W-1:0] r_st [SHAMT_W+1];

  assign fill    = arith_i & d_i[MSB];
  assign l_st[0] = d_i;
  assign r_st[0] = d_i;

  for (genvar g = 0; g < SHAMT_W; g++) begin : g_stage
    localparam int S = 1 << g;
    assign l_st[g+1] = amt_i[g] ? {l_st[g][DATA_W-1-S:0], {S{1'b0}}} : l_st[g];
    assign r_st[g+1] = amt_i[g] ? {{S{fill}}, r_st[g][DATA_W-1:S]}   : r_st[g];
  end

  assign q_o = left_i ? l_st[SHAMT_W] : r_st[SHAMT_W];

  always_comb begin
    if (left_i) begin
      // R5
      shl_zero_fill_chk: assert (q_o == (d_i << amt_i));
    end else if (!fill) begin
      // R7
      shr_pos_fill_chk: assert (q_o == (d_i >> amt_i));
    end else begin
      // R7
      shr_sign_fill_chk: assert (q_o[MSB]);
    end
  end

endmodule

// File: rtl/reg_alu.sv
module reg_alu
  import reg_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [5:0]         op_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               zero_o
);

  alu_op_e           op;
  logic              sub, sh_left, sh_arith, sh_var;
  logic [SHAMT_W-1:0] sh_amt;
  logic_fn_e         lfn;
  logic [DATA_W-1:0] sum, lg, sh;
  logic              lt;

  assign op       = alu_op_e'(op_i);
  assign sub      = (op == OP_SUB) || (op == OP_SLT);
  assign sh_left  = (op == OP_SLL) || (op == OP_SLLV);
  assign sh_arith = (op == OP_SRA) || (op == OP_SRAV);
  assign sh_var   = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
  assign sh_amt   = sh_var ? b_i[SHAMT_W-1:0] : shamt_i;

  always_comb begin
    unique case (op)
      OP_AND:  lfn = LF_AND;
      OP_OR:   lfn = LF_OR;
      OP_XOR:  lfn = LF_XOR;
      default: lfn = LF_NOR;
    endcase
  end

  alu_addsub #(.DATA_W(DATA_W)) i_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(sub), .sum_o(sum), .lt_o(lt)
  );

  alu_logic #(.DATA_W(DATA_W)) i_logic (
    .a_i(a_i), .b_i(b_i), .fn_i(lfn), .q_o(lg)
  );

  alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) i_shifter (
    .d_i(a_i), .amt_i(sh_amt), .left_i(sh_left), .arith_i(sh_arith), .q_o(sh)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:                   result_o = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:    result_o = lg;
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV, OP_SRAV:        result_o = sh;
      OP_SLT:                           result_o = {{(DATA_W-1){1'b0}}, lt};
      default:                          result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;

  always_comb begin
    if (op == OP_SUB && a_i == b_i) begin
      // R9
      eq_sub_zero_chk: assert (zero_o);
    end
    if (op == OP_SLT) begin
      // R8
      slt_binary_chk: assert (result_o[DATA_W-1:1] == '0);
    end
  end

endmodule

// File: tb/test_reg_alu.sv
`timescale 1ns/1ps
module test_reg_alu;
  localparam int DW = 32;
  localparam int SW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [DW-1:0] a, b, res;
  logic [SW-1:0] sh;
  logic [5:0]    op;
  logic          zf;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [31:0] seed = 32'h1234_5678;

  reg_alu #(.DATA_W(DW), .SHAMT_W(SW)) i_reg_alu (
    .a_i(a), .b_i(b), .shamt_i(sh), .op_i(op), .result_o(res), .zero_o(zf)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic string req_of(input int o);
    case (o)
      32: return "R1";
      34: return "R2";
      36, 37, 38: return "R3";
      39: return "R4";
      0, 2: return "R5";
      4, 6: return "R6";
      3, 7: return "R7";
      42: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] model(input int o, input logic [31:0] x,
                                        input logic [31:0] y, input int s);
    int vs = int'(y % 32);
    case (o)
      32: return x + y;
      34: return x - y;
      36: return x & y;
      37: return x | y;
      38: return x ^ y;
      39: return ~(x | y);
      0:  return x << s;
      2:  return x >> s;
      3:  return 32'($signed(x) >>> s);
      4:  return x << vs;
      6:  return x >> vs;
      7:  return 32'($signed(x) >>> vs);
      42: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply(input int o, input logic [31:0] x, input logic [31:0] y, input int s);
    logic [31:0] exp;
    @(posedge clk);
    op = 6'(o); a = x; b = y; sh = SW'(s);
    @(negedge clk);
    exp = model(o, x, y, s);
    n_vec++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d result actual=%h expected=%h",
               req_of(o), o, x, y, s, res, exp);
    end
    if (zf !== (exp == 32'd0)) begin
      n_fail++;
      $display("FAIL R9 op=%0d zero actual=%b expected=%b", o, zf, exp == 32'd0);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    int ops[13] = '{0, 2, 3, 4, 6, 7, 32, 34, 36, 37, 38, 39, 42};
    op = 6'd32; a = '0; b = '0; sh = '0;
    apply(32, 32'h0, 32'h0, 0);                    // start state, R1 R9
    apply(32, 32'hFFFF_FFFF, 32'h1, 0);            // R1 wrap, zero
    apply(34, 32'h0, 32'h1, 0);                    // R2 wrap
    apply(34, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0);    // R2 equal -> R9
    apply(36, 32'hF0F0_1234, 32'h0000_FFFF, 0);    // R3 zero-extended imm
    apply(39, 32'h0, 32'h0, 0);                    // R4 all ones
    apply(39, 32'hAAAA_0000, 32'h5555_0000, 0);    // R4 upper zero
    apply(0, 32'h8000_0001, 32'hFFFF_FFFF, 31);    // R5 b ignored
    apply(2, 32'h8000_0000, 32'h0000_0003, 31);    // R5 zero fill
    apply(3, 32'h8000_0000, 32'h0, 31);            // R7 sign fill
    apply(3, 32'h7FFF_FFFF, 32'h0, 30);            // R7 positive
    apply(7, 32'h8000_1000, 32'hFFFF_FFE4, 0);     // R7 variable count 4
    apply(6, 32'h1234_5678, 32'h0000_0020, 7);     // R6 count 0, shamt ignored
    apply(4, 32'h0000_0001, 32'hFFFF_FFE1, 0);     // R6 upper bits ignored
    apply(4, 32'h0000_0001, 32'h0000_001F, 0);     // R6 max count
    apply(42, 32'hFFFF_FFFF, 32'h0000_0001, 0);    // R8 -1 < 1
    apply(42, 32'h7FFF_FFFF, 32'h8000_0000, 0);    // R8 signed boundary
    apply(42, 32'h8000_0000, 32'h7FFF_FFFF, 0);    // R8
    apply(42, 32'h5, 32'h5, 0);                    // R8 equal -> 0
    apply(63, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5);    // R10
    apply(1, 32'h1234_5678, 32'h1, 3);             // R10
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] ra, rb;
      int ro;
      seed = next_rand(seed); ra = seed;
      seed = next_rand(seed); rb = seed;
      seed = next_rand(seed);
      if (seed[3:0] == 4'hF) ro = int'(seed[9:4]);
      else ro = ops[seed[9:4] % 13];
      if (seed[12:10] == 3'd0) rb = ra;
      apply(ro, ra, rb, int'(seed[20:16]));
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule